// File: doc/BRIEF.md
# Keyed Configuration-Mode Register Unit

This unit guards a small bank of sixteen 8-bit configuration registers on an 8-bit I/O bus, the way a multi-function I/O controller keeps its setup registers out of reach of normal traffic. Two bus addresses belong to it: a select port and a data port one address above. A strap input moves the select port between a primary address (0x3F0) and an alternate one (0x370).

Software unlocks the bank by writing a key byte to the select port on two bus writes in a row. Once unlocked, a write to the select port picks a register index, and reads and writes of the data port reach the register at that index. Writing 0xAA to the select port locks the bank again. Index 0x0D is a read-only device identification byte. Two registers drive hardware outputs: the register at index 1 picks the parallel-port base address and a standard-only bit, and the register at index 4 holds the extended-mode field and the EPP protocol flavour bit.

All register writes take effect at the clock edge of the write. Reads are combinational from the current state.

Top module: `cfgkey_unit`

## Requirements
- R1: After reset the bank is locked (`cfg_open`=0), the data port reads 0xFF, and the outputs show the register at index 1 at its reset value 0x0A: `lpt_en`=1, `lpt_base`=0x378, `std_only`=1, `port_mode`=0, `epp_v17`=0.
- R2: The select port is at 0x3F0 when `strap_alt`=0 and at 0x370 when `strap_alt`=1. The data port is at select+1. A key written to the address of the other strap setting does not count as a key write.
- R3: Two consecutive bus writes of the key (parameter, default 0x55) to the select port set `cfg_open` after the second write. One key write alone leaves the bank locked.
- R4: Once one key write has been seen, any bus write that is not a key write to the select port, at any address, cancels it. The next key write then counts as the first of a new pair.
- R5: While unlocked, a select-port write stores the written byte as the index. Data-port writes load the register at that index. Data-port reads return it. For an index of 0x10 or above, reads return 0x00 and writes change nothing.
- R6: Index 0x0D reads as the device ID (parameter, default 0x65), and writes to it are ignored.
- R7: While locked, data-port reads return 0xFF and data-port writes leave every register unchanged.
- R8: Writing 0xAA to the select port while unlocked clears `cfg_open` after that write. It also resets the index to 0, and the index is 0 again after the next unlock.
- R9: Bits [1:0] of register 1 set the parallel port base: 0 gives `lpt_en`=0 and `lpt_base`=0, 1 gives 0x3BC, 2 gives 0x378, 3 gives 0x278. Any non-zero code gives `lpt_en`=1.
- R10: Bit 3 of register 1 drives `std_only`. When that bit is 1, `port_mode` reads 0 (SPP). When it is 0, `port_mode` follows bits [1:0] of register 4: 0 SPP, 1 EPP+SPP, 2 ECP, 3 ECP+EPP.
- R11: Bit 6 of register 4 drives `epp_v17`: 0 selects EPP 1.9 behaviour, 1 selects the older 1.7 behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_alt | input | 1 | Selects the alternate select-port address (static) |
| bus_addr | input | ADDR_W | I/O address of the current access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0xFF when the unit does not answer |
| cfg_open | output | 1 | Configuration mode active |
| lpt_en | output | 1 | Parallel port enabled |
| lpt_base | output | ADDR_W | Decoded parallel port base address |
| std_only | output | 1 | Standard-only operation selected |
| port_mode | output | 2 | Effective parallel port mode code |
| epp_v17 | output | 1 | Older EPP protocol flavour selected |

## Verification
The bench goes after the unlock sequence. It interleaves a stray select value, a data-port write and a key sent to the wrong strap address between key writes. A design that only counted key writes, or that ignored writes to other addresses, would open the bank when it should stay locked. Under both strap settings the bench sweeps every index and checks that the read-only ID byte survives a write. It also checks that an out-of-range index neither aliases onto a low register nor reads back stale data, and that a write while locked leaves register 0 unchanged. It then sweeps all 64 combinations of base code, standard bit, extended-mode field and protocol bit. That sweep catches a swapped base table, or a mode field that is not forced to SPP when standard-only is set.

// File: rtl/cfgkey_pkg.sv
package cfgkey_pkg;

   typedef enum logic [1:0] {
      UL_LOCKED = 2'd0,
      UL_ARMED  = 2'd1,
      UL_OPEN   = 2'd2
   } unlock_state_t;

   typedef enum logic [1:0] {
      PM_SPP     = 2'd0,
      PM_EPP_SPP = 2'd1,
      PM_ECP     = 2'd2,
      PM_ECP_EPP = 2'd3
   } port_mode_t;

   localparam int REG_BASE_IDX = 1;
   localparam int REG_EXT_IDX  = 4;
   localparam int REG_ID_IDX   = 13;

   localparam logic [7:0] EXIT_CODE = 8'hAA;

   function automatic logic [15:0] lpt_base_of(input logic [1:0] code);
      logic [15:0] b;
      unique case (code)
         2'd1:    b = 16'h03BC;
         2'd2:    b = 16'h0378;
         2'd3:    b = 16'h0278;
         default: b = 16'h0000;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/cfgkey_unlock.sv
module cfgkey_unlock
   import cfgkey_pkg::*;
#(
   parameter logic [7:0] KEY = 8'h55
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       any_wr,
   input  logic       sel_wr,
   input  logic [7:0] wdata,
   output logic       open,
   output logic [7:0] index
);

   unlock_state_t st_q;
   logic          key_hit;

   assign key_hit = sel_wr && (wdata == KEY);
   assign open    = (st_q == UL_OPEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= UL_LOCKED;
         index <= 8'h00;
      end else begin
         unique case (st_q)
            UL_LOCKED: begin
               if (key_hit) st_q <= UL_ARMED;
            end
            UL_ARMED: begin
               if (any_wr) begin
                  if (key_hit) begin
                     st_q  <= UL_OPEN;
                     index <= 8'h00;
                  end else begin
                     st_q <= UL_LOCKED;
                  end
               end
            end
            UL_OPEN: begin
               if (sel_wr) begin
                  if (wdata == EXIT_CODE) begin
                     st_q  <= UL_LOCKED;
                     index <= 8'h00;
                  end else begin
                     index <= wdata;
                  end
               end
            end
            default: st_q <= UL_LOCKED;
         endcase
      end
   end

endmodule

// File: rtl/cfgkey_regfile.sv
module cfgkey_regfile
   import cfgkey_pkg::*;
#(
   parameter int         NUM_REGS = 16,
   parameter logic [7:0] DEV_ID   = 8'h65,
   parameter logic [7:0] CR1_INIT = 8'h0A,
   localparam int        IDX_W    = $clog2(NUM_REGS)
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] index,
   input  logic [7:0] wdata,
   output logic [7:0] rd_val,
   output logic [1:0] base_code,
   output logic       std_bit,
   output logic [1:0] ext_field,
   output logic       epp_bit
);

   logic [7:0] regs [NUM_REGS];
   logic       in_range;
   logic [IDX_W-1:0] idx;

   assign in_range = ({24'd0, index} < NUM_REGS);
   assign idx      = index[IDX_W-1:0];

   function automatic logic [7:0] init_of(input int i);
      return (i == REG_BASE_IDX) ? CR1_INIT : 8'h00;
   endfunction

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      if (i == REG_ID_IDX) begin : g_id
         assign regs[i] = DEV_ID;
      end else begin : g_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs[i] <= init_of(i);
            else if (wr && in_range && (idx == IDX_W'(i)))
               regs[i] <= wdata;
         end
      end
   end

   assign rd_val    = in_range ? regs[idx] : 8'h00;
   assign base_code = regs[REG_BASE_IDX][1:0];
   assign std_bit   = regs[REG_BASE_IDX][3];
   assign ext_field = regs[REG_EXT_IDX][1:0];
   assign epp_bit   = regs[REG_EXT_IDX][6];

endmodule

// File: rtl/cfgkey_decode.sv
module cfgkey_decode
   import cfgkey_pkg::*;
#(
   parameter int ADDR_W = 10
)(
   input  logic [1:0]        base_code,
   input  logic              std_bit,
   input  logic [1:0]        ext_field,
   input  logic              epp_bit,
   output logic              lpt_en,
   output logic [ADDR_W-1:0] lpt_base,
   output logic              std_only,
   output logic [1:0]        port_mode,
   output logic              epp_v17
);

   logic [15:0] base_full;

   assign base_full = lpt_base_of(base_code);
   assign lpt_en    = (base_code != 2'd0);
   assign lpt_base  = base_full[ADDR_W-1:0];
   assign std_only  = std_bit;
   assign port_mode = std_bit ? 2'(PM_SPP) : ext_field;
   assign epp_v17   = epp_bit;

endmodule

// File: rtl/cfgkey_unit.sv
module cfgkey_unit
   import cfgkey_pkg::*;
#(
   parameter int                ADDR_W   = 10,
   parameter int                NUM_REGS = 16,
   parameter logic [7:0]        KEY      = 8'h55,
   parameter logic [7:0]        DEV_ID   = 8'h65,
   parameter logic [7:0]        CR1_INIT = 8'h0A,
   parameter logic [ADDR_W-1:0] SEL_PRI  = ADDR_W'(16'h03F0),
   parameter logic [ADDR_W-1:0] SEL_ALT  = ADDR_W'(16'h0370)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_alt,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              cfg_open,
   output logic              lpt_en,
   output logic [ADDR_W-1:0] lpt_base,
   output logic              std_only,
   output logic [1:0]        port_mode,
   output logic              epp_v17
);

   if (ADDR_W < 10 || ADDR_W > 16) begin : g_bad_addr_w
      $error("cfgkey_unit: ADDR_W must be 10..16");
   end
   if (NUM_REGS < 16 || NUM_REGS > 128) begin : g_bad_num_regs
      $error("cfgkey_unit: NUM_REGS must be 16..128");
   end
   if (KEY == EXIT_CODE) begin : g_bad_key
      $error("cfgkey_unit: KEY must differ from the exit code");
   end
   if (SEL_PRI == SEL_ALT) begin : g_bad_sel
      $error("cfgkey_unit: select addresses must differ");
   end

   logic [ADDR_W-1:0] sel_addr;
   logic [ADDR_W-1:0] dat_addr;
   logic              sel_wr;
   logic              dat_wr;
   logic              dat_rd;
   logic [7:0]        index;
   logic [7:0]        rd_val;
   logic [1:0]        base_code;
   logic              std_bit;
   logic [1:0]        ext_field;
   logic              epp_bit;

   assign sel_addr = strap_alt ? SEL_ALT : SEL_PRI;
   assign dat_addr = sel_addr + ADDR_W'(1);
   assign sel_wr   = bus_wr && (bus_addr == sel_addr);
   assign dat_wr   = bus_wr && (bus_addr == dat_addr) && cfg_open;
   assign dat_rd   = bus_rd && (bus_addr == dat_addr) && cfg_open;

   cfgkey_unlock #(.KEY(KEY)) u_unlock (
      .clk    (clk),
      .rst_n  (rst_n),
      .any_wr (bus_wr),
      .sel_wr (sel_wr),
      .wdata  (bus_wdata),
      .open   (cfg_open),
      .index  (index)
   );

   cfgkey_regfile #(
      .NUM_REGS (NUM_REGS),
      .DEV_ID   (DEV_ID),
      .CR1_INIT (CR1_INIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (dat_wr),
      .index     (index),
      .wdata     (bus_wdata),
      .rd_val    (rd_val),
      .base_code (base_code),
      .std_bit   (std_bit),
      .ext_field (ext_field),
      .epp_bit   (epp_bit)
   );

   cfgkey_decode #(.ADDR_W(ADDR_W)) u_dec (
      .base_code (base_code),
      .std_bit   (std_bit),
      .ext_field (ext_field),
      .epp_bit   (epp_bit),
      .lpt_en    (lpt_en),
      .lpt_base  (lpt_base),
      .std_only  (std_only),
      .port_mode (port_mode),
      .epp_v17   (epp_v17)
   );

   assign bus_rdata = dat_rd ? rd_val : 8'hFF;

endmodule

// File: rtl/cfgkey_chk.sv
module cfgkey_chk #(
   parameter int         ADDR_W = 10,
   parameter logic [7:0] KEY    = 8'h55
)(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] sel_addr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        bus_rdata,
   input logic              cfg_open,
   input logic              lpt_en,
   input logic [ADDR_W-1:0] lpt_base,
   input logic              std_only,
   input logic [1:0]        port_mode
);

   AST_LOCKED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_open && bus_rd) |-> (bus_rdata == 8'hFF)); // R7

   AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_open) |-> $past(bus_wr && bus_addr == sel_addr && bus_wdata == KEY)); // R3

   AST_EXIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && bus_wr && bus_addr == sel_addr && bus_wdata == 8'hAA) |=> !cfg_open); // R8

   AST_LOCKED_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_open |=> ($stable(lpt_base) && $stable(port_mode) && $stable(std_only))); // R7

   AST_DISABLED_BASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !lpt_en |-> (lpt_base == '0)); // R9

   AST_STD_FORCES_SPP: assert property (@(posedge clk) disable iff (!rst_n)
      std_only |-> (port_mode == 2'd0)); // R10

endmodule

bind cfgkey_unit cfgkey_chk #(.ADDR_W(ADDR_W), .KEY(KEY)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sel_addr  (sel_addr),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .cfg_open  (cfg_open),
   .lpt_en    (lpt_en),
   .lpt_base  (lpt_base),
   .std_only  (std_only),
   .port_mode (port_mode)
);

// File: tb/sim_cfgkey_unit.sv
module sim_cfgkey_unit;

   localparam int         AW     = 10;
   localparam logic [7:0] KEY    = 8'h55;
   localparam logic [7:0] DEV_ID = 8'h65;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          strap_alt = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [7:0]    bus_wdata = 8'h00;
   logic [7:0]    bus_rdata;
   logic          cfg_open;
   logic          lpt_en;
   logic [AW-1:0] lpt_base;
   logic          std_only;
   logic [1:0]    port_mode;
   logic          epp_v17;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   cfgkey_unit u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_alt (strap_alt),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cfg_open  (cfg_open),
      .lpt_en    (lpt_en),
      .lpt_base  (lpt_base),
      .std_only  (std_only),
      .port_mode (port_mode),
      .epp_v17   (epp_v17)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
      bus_addr = a;
      bus_rd   = 1'b1;
      #2;
      d        = bus_rdata;
      bus_rd   = 1'b0;
   endtask

   function automatic logic [7:0] pat(input int i, input int s);
      return 8'((i * 29 + s * 7) ^ 8'hA5);
   endfunction

   function automatic int base_exp(input int b);
      return (b == 0) ? 0 : (b == 1) ? 'h3BC : (b == 2) ? 'h378 : 'h278;
   endfunction

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 cfg_open", cfg_open, 0);
      rd(10'h3F1, v); chk("R1 locked read", v, 'hFF);
      chk("R1 lpt_en", lpt_en, 1);
      chk("R1 lpt_base", lpt_base, 'h378);
      chk("R1 std_only", std_only, 1);
      chk("R1 port_mode", port_mode, 0);
      chk("R1 epp_v17", epp_v17, 0);

      for (int s = 0; s < 2; s++) begin
         logic [AW-1:0] sa, da, other;
         strap_alt = s[0];
         sa    = (s == 1) ? 10'h370 : 10'h3F0;
         da    = sa + 10'd1;
         other = (s == 1) ? 10'h3F0 : 10'h370;

         // R3 single key does not unlock
         wr(sa, KEY);
         chk("R3 single key", cfg_open, 0);
         rd(da, v); chk("R3 single key read", v, 'hFF);
         // R2 second key at the other strap's address
         wr(other, KEY);
         chk("R2 wrong port key", cfg_open, 0);
         // R4 stray select value between keys
         wr(sa, KEY); wr(sa, 8'h00); wr(sa, KEY);
         chk("R4 stray select value", cfg_open, 0);
         // R4 data-port write between keys
         wr(da, 8'h3C); wr(sa, KEY);
         chk("R4 data write interrupts", cfg_open, 0);
         wr(sa, KEY);
         chk("R3 double key opens", cfg_open, 1);

         // R5 R6 sweep of every index
         for (int i = 0; i < 16; i++) begin
            wr(sa, 8'(i)); wr(da, pat(i, s));
         end
         for (int i = 0; i < 16; i++) begin
            wr(sa, 8'(i)); rd(da, v);
            if (i == 13) chk("R6 id read-only", v, DEV_ID);
            else         chk("R5 register readback", v, pat(i, s));
         end
         // R5 out of range index
         wr(sa, 8'h10); wr(da, 8'h77); rd(da, v);
         chk("R5 out of range reads zero", v, 0);
         wr(sa, 8'h00); rd(da, v);
         chk("R5 no alias onto reg0", v, pat(0, s));
         // R8 exit, R7 locked access
         wr(sa, 8'h07);
         wr(sa, 8'hAA);
         chk("R8 exit closes", cfg_open, 0);
         rd(da, v); chk("R7 locked data read", v, 'hFF);
         wr(da, 8'h12);
         wr(sa, KEY); wr(sa, KEY);
         chk("R8 reopen", cfg_open, 1);
         rd(da, v); chk("R8 index reset / R7 write ignored", v, pat(0, s));

         // R9 R10 R11 sweep of the mode controls
         for (int b = 0; b < 4; b++)
            for (int m = 0; m < 2; m++)
               for (int e = 0; e < 4; e++)
                  for (int p = 0; p < 2; p++) begin
                     wr(sa, 8'h01); wr(da, 8'((m << 3) | b));
                     wr(sa, 8'h04); wr(da, 8'((p << 6) | e));
                     chk("R9 lpt_en", lpt_en, (b != 0) ? 1 : 0);
                     chk("R9 lpt_base", lpt_base, base_exp(b));
                     chk("R10 std_only", std_only, m);
                     chk("R10 port_mode", port_mode, (m == 1) ? 0 : e);
                     chk("R11 epp_v17", epp_v17, p);
                  end
         wr(sa, 8'hAA);
         chk("R8 exit after sweep", cfg_open, 0);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule